// File: doc/BRIEF.md
# Receive Page Ring Manager

This block places incoming receive frames into a circular buffer made of 256-byte pages in a local byte-wide memory. Two configuration inputs bound the ring: a first page, which belongs to the ring, and a stop page, which does not. A frame's bytes go into the memory in arrival order, starting four bytes into the page named by the current-page register. Writing runs across page edges, and after the last ring page it continues at the first ring page. When the frame ends, four header bytes are written into the reserved slot at the front of the frame's first page. The header holds the receive status, the link to the next free page, and the byte count (low byte, then high byte). The current-page register then moves to that next page, and the host treats the ring as empty while its read page equals the current page.

The host owns a boundary page, which it keeps one page behind its next read page. If a byte would land in the boundary page, the frame is abandoned and an overwrite warning pulses. When that frame's last byte arrives, a missed-frame pulse follows, and the frame is never committed. A frame whose status reports an error is dropped by leaving the current page where it was, unless the keep-errored input is high. Bytes arrive on a valid/data/last stream, with the status byte presented alongside the last byte. The source must leave at least four idle cycles after each last byte.

The controller has four states. IDLE waits for a first byte. DATA stores the following bytes. SKIP discards the rest of an abandoned frame. HDR writes the four header bytes. The transitions are:
- IDLE→DATA on an accepted first byte.
- IDLE or DATA→HDR on an accepted last byte of a frame that will be kept.
- IDLE or DATA→IDLE on a last byte that is dropped or blocked.
- IDLE or DATA→SKIP on a blocked byte that is not last.
- SKIP→IDLE on the last byte.
- HDR→IDLE after the fourth header byte.

Top module: `rxring_mgr`

## Requirements
- R1: While reset is held, the current page loads the first ring page. After reset, and before any input, there are no memory writes and no pulses.
- R2: The first byte of a frame is written at offset 4 of the current page, and each later byte goes to the next address. After offset 255 the next page follows, and after page (stop−1) the first ring page follows.
- R3: In the four cycles after an accepted last byte, the header is written to offsets 0,1,2,3 of the frame's first page. Offset 0 holds the status, offset 1 the next page, offset 2 the count low byte and offset 3 the count high byte. The count is the number of stream bytes, with the CRC bytes included and the header excluded.
- R4: The next page is the page after the one holding the final data byte, wrapped into the ring. The current page takes this value on the cycle frame_done pulses, which is the fourth header write. At no other time does the current page change.
- R5: A byte that would go into the boundary page is not written, and ovw_warn pulses in that cycle. This includes a first byte arriving when the current page equals the boundary page. All later bytes of that frame are dropped.
- R6: An abandoned frame's last byte pulses missed. No header is written for it and the current page does not change.
- R7: Status bit 0 means received intact, bit 1 CRC error, bit 2 alignment error and bit 3 FIFO overrun. A frame is in error if bit 0 is 0 or any of bits 1 to 3 is 1. With keep_bad low, an errored frame gets no header and the current page keeps its value.
- R8: With keep_bad high, an errored frame is committed like a good one, and its status byte is stored unchanged.
- R9: A frame whose last byte lands at offset 255 links to the very next page. It raises no warning even when that next page is the boundary page.
- R10: Every memory write lands in a ring page, meaning a page that is at least the first page and below the stop page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_first | input | 8 | First page of the ring (inclusive) |
| pg_stop | input | 8 | Stop page of the ring (exclusive) |
| bnd_pg | input | 8 | Host boundary page |
| keep_bad | input | 1 | Commit frames that carry error status |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_status | input | 8 | Receive status, sampled with the last byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| curr_pg | output | 8 | Current page register |
| frame_done | output | 1 | Pulses when a frame is committed |
| ovw_warn | output | 1 | Overwrite warning pulse |
| missed | output | 1 | Missed-frame pulse |

## Verification
Some properties are checked on every cycle. Writes stay inside the ring. The current page stays inside the ring and moves only on a commit pulse. A warning never comes with a write. A missed pulse always falls on a valid last byte. The exact contents of the ring can only be shown by the bench's frames: byte placement across page edges and the wrap, the header fields, the next-page link, and the choice to drop or keep errored frames. The same holds for the exact-fill corner and the blocked-start case.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_SKIP,
        ST_HDR
    } rx_state_e;

    localparam int HDR_LEN   = 4;
    localparam int CNT_W     = 16;
    localparam int ST_INTACT = 0;
    localparam int ST_CRC    = 1;
    localparam int ST_ALIGN  = 2;
    localparam int ST_OVRUN  = 3;
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr
    import rxring_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             take,
    input  logic             last,
    input  logic [PG_W-1:0]  cur,
    input  logic [PG_W-1:0]  pfirst,
    input  logic [PG_W-1:0]  pstop,
    input  logic [PG_W-1:0]  bnd,
    input  logic [7:0]       status,
    output logic [PG_W-1:0]  a_pg,
    output logic [OFF_W-1:0] a_off,
    output logic             blocked,
    output logic [PG_W-1:0]  nxt_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [7:0]       stat_q
);
    logic [PG_W-1:0]  wpg;
    logic [OFF_W-1:0] woff;

    function automatic logic [PG_W-1:0] step(input logic [PG_W-1:0] p,
                                             input logic [PG_W-1:0] lo,
                                             input logic [PG_W-1:0] hi);
        logic [PG_W-1:0] q;
        q = p + 1'b1;
        return (q == hi) ? lo : q;
    endfunction

    always_comb begin
        a_pg    = first ? cur : wpg;
        a_off   = first ? OFF_W'(HDR_LEN) : woff;
        blocked = first ? (cur == bnd) : ((woff == '0) && (wpg == bnd));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpg    <= '0;
            woff   <= '0;
            nxt_q  <= '0;
            cnt_q  <= '0;
            stat_q <= '0;
        end else if (take) begin
            if (&a_off) begin
                wpg  <= step(a_pg, pfirst, pstop);
                woff <= '0;
            end else begin
                wpg  <= a_pg;
                woff <= a_off + 1'b1;
            end
            cnt_q <= first ? CNT_W'(1) : cnt_q + 1'b1;
            if (last) begin
                nxt_q  <= step(a_pg, pfirst, pstop);
                stat_q <= status;
            end
        end
    end
endmodule

// File: rtl/rxring_hdr.sv
module rxring_hdr
    import rxring_pkg::*;
#(
    parameter int PG_W = 8
) (
    input  logic [1:0]       idx,
    input  logic [7:0]       stat,
    input  logic [PG_W-1:0]  nxt,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       byte_o
);
    always_comb begin
        unique case (idx)
            2'd0: byte_o = stat;
            2'd1: byte_o = 8'(nxt);
            2'd2: byte_o = cnt[7:0];
            2'd3: byte_o = cnt[15:8];
        endcase
    end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int PG_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic            rx_last,
    input  logic [3:0]      st_lo,
    input  logic            keep_bad,
    input  logic            blocked,
    input  logic [PG_W-1:0] nxt_pg,
    input  logic [PG_W-1:0] pfirst,
    output logic            first,
    output logic            take,
    output logic            hdr_we,
    output logic [1:0]      hidx,
    output logic [PG_W-1:0] curr,
    output logic            done,
    output logic            ovw,
    output logic            miss
);
    rx_state_e st, st_nx;
    logic      bad, keep;

    always_comb begin
        bad  = !st_lo[ST_INTACT] || st_lo[ST_CRC] || st_lo[ST_ALIGN] || st_lo[ST_OVRUN];
        keep = !bad || keep_bad;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_DATA: begin
                if (rx_valid) begin
                    if (blocked)
                        st_nx = rx_last ? ST_IDLE : ST_SKIP;
                    else if (rx_last)
                        st_nx = keep ? ST_HDR : ST_IDLE;
                    else
                        st_nx = ST_DATA;
                end
            end
            ST_SKIP: if (rx_valid && rx_last) st_nx = ST_IDLE;
            ST_HDR:  if (hidx == 2'd3) st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            hidx <= '0;
            curr <= pfirst;
        end else begin
            st   <= st_nx;
            hidx <= (st == ST_HDR) ? hidx + 1'b1 : 2'd0;
            if (done) curr <= nxt_pg;
        end
    end

    // outputs
    always_comb begin
        first  = (st == ST_IDLE);
        take   = 1'b0;
        hdr_we = 1'b0;
        done   = 1'b0;
        ovw    = 1'b0;
        miss   = 1'b0;
        unique case (st)
            ST_IDLE, ST_DATA: begin
                if (rx_valid) begin
                    if (blocked) begin
                        ovw  = 1'b1;
                        miss = rx_last;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            ST_SKIP: miss = rx_valid && rx_last;
            ST_HDR: begin
                hdr_we = 1'b1;
                done   = (hidx == 2'd3);
            end
        endcase
    end
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
    import rxring_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PG_W-1:0]       pg_first,
    input  logic [PG_W-1:0]       pg_stop,
    input  logic [PG_W-1:0]       bnd_pg,
    input  logic                  keep_bad,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_last,
    input  logic [7:0]            rx_status,
    output logic                  mem_we,
    output logic [PG_W+OFF_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       curr_pg,
    output logic                  frame_done,
    output logic                  ovw_warn,
    output logic                  missed
);
    localparam int AW = PG_W + OFF_W;

    logic             first, take, hdr_we, blocked;
    logic [1:0]       hidx;
    logic [PG_W-1:0]  a_pg, nxt_q;
    logic [OFF_W-1:0] a_off;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       stat_q, hbyte;

    rxring_ctrl #(.PG_W(PG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
        .st_lo(rx_status[3:0]), .keep_bad(keep_bad), .blocked(blocked),
        .nxt_pg(nxt_q), .pfirst(pg_first), .first(first), .take(take),
        .hdr_we(hdr_we), .hidx(hidx), .curr(curr_pg), .done(frame_done),
        .ovw(ovw_warn), .miss(missed)
    );

    rxring_ptr #(.PG_W(PG_W), .OFF_W(OFF_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .first(first), .take(take), .last(rx_last),
        .cur(curr_pg), .pfirst(pg_first), .pstop(pg_stop), .bnd(bnd_pg),
        .status(rx_status), .a_pg(a_pg), .a_off(a_off), .blocked(blocked),
        .nxt_q(nxt_q), .cnt_q(cnt_q), .stat_q(stat_q)
    );

    rxring_hdr #(.PG_W(PG_W)) u_hdr (
        .idx(hidx), .stat(stat_q), .nxt(nxt_q), .cnt(cnt_q), .byte_o(hbyte)
    );

    always_comb begin
        mem_we    = take || hdr_we;
        mem_addr  = hdr_we ? AW'({curr_pg, {(OFF_W-2){1'b0}}, hidx}) : AW'({a_pg, a_off});
        mem_wdata = hdr_we ? hbyte : rx_data;
    end
endmodule

// File: rtl/rxring_mgr_chk.sv
module rxring_mgr_chk #(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [PG_W-1:0]       pg_first,
    input logic [PG_W-1:0]       pg_stop,
    input logic                  rx_valid,
    input logic                  rx_last,
    input logic                  mem_we,
    input logic [PG_W+OFF_W-1:0] mem_addr,
    input logic [PG_W-1:0]       curr_pg,
    input logic                  frame_done,
    input logic                  ovw_warn,
    input logic                  missed
);
    logic [PG_W-1:0] wr_pg;
    assign wr_pg = mem_addr[PG_W+OFF_W-1:OFF_W];

    a_r10_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_pg >= pg_first && wr_pg < pg_stop));

    a_r1_curr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (curr_pg >= pg_first && curr_pg < pg_stop));

    a_r5_no_write_on_warn: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_warn |-> !mem_we);

    a_r6_miss_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        missed |-> (rx_valid && rx_last));

    a_r4_curr_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(curr_pg));

    a_r3_commit_writes: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> mem_we);
endmodule

bind rxring_mgr rxring_mgr_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pg_first(pg_first), .pg_stop(pg_stop),
    .rx_valid(rx_valid), .rx_last(rx_last), .mem_we(mem_we),
    .mem_addr(mem_addr), .curr_pg(curr_pg), .frame_done(frame_done),
    .ovw_warn(ovw_warn), .missed(missed)
);

// File: tb/rxring_mgr_test.sv
module rxring_mgr_test;
    localparam int PER   = 10;
    localparam int FIRST = 8'h10;
    localparam int STOP  = 8'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pg_first = 8'(FIRST), pg_stop = 8'(STOP), bnd_pg = 8'h17;
    logic       keep_bad = 1'b0, rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0, rx_status = '0;
    logic        mem_we, frame_done, ovw_warn, missed;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, curr_pg;

    int checks = 0, errors = 0;
    int wr_n = 0, done_n = 0, ovw_n = 0, miss_n = 0;
    logic [7:0] mem [0:4095];

    rxring_mgr uut (
        .clk(clk), .rst_n(rst_n), .pg_first(pg_first), .pg_stop(pg_stop),
        .bnd_pg(bnd_pg), .keep_bad(keep_bad), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_status(rx_status),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .curr_pg(curr_pg), .frame_done(frame_done), .ovw_warn(ovw_warn),
        .missed(missed)
    );

    always #(PER/2) clk = ~clk;

    // sample between the input change (negedge) and the active edge
    always begin
        @(negedge clk);
        #(PER/5);
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] = mem_wdata;
                wr_n++;
            end
            if (frame_done) done_n++;
            if (ovw_warn)   ovw_n++;
            if (missed)     miss_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int loc(input int pg, input int q);
        int p;
        p = FIRST + ((pg - FIRST + q / 256) % (STOP - FIRST));
        return (p * 256 + q % 256) % 4096;
    endfunction

    function automatic int after(input int pg);
        return (pg + 1 == STOP) ? FIRST : pg + 1;
    endfunction

    task automatic sentinel(input int pg);
        for (int k = 0; k < 256; k++) mem[(pg * 256 + k) % 4096] = 8'hEE;
    endtask

    task automatic send(input int len, input int seed, input int st);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_data   = 8'(seed + i);
            rx_last   = (i == len - 1);
            rx_status = 8'(st);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input int pg, input int len,
                               input int seed, input int st, input int nxt);
        int bad_i;
        bad_i = -1;
        for (int i = len - 1; i >= 0; i--)
            if (mem[loc(pg, 4 + i)] !== 8'(seed + i)) bad_i = i;
        chk(bad_i < 0, {tag, " R2 data"}, (bad_i < 0) ? 0 : int'(mem[loc(pg, 4 + bad_i)]),
            (bad_i < 0) ? 0 : (seed + bad_i) & 255);
        chk(mem[loc(pg, 0)] === 8'(st), {tag, " R3 status"}, int'(mem[loc(pg, 0)]), st);
        chk(mem[loc(pg, 1)] === 8'(nxt), {tag, " R4 next"}, int'(mem[loc(pg, 1)]), nxt);
        chk(mem[loc(pg, 2)] === 8'(len), {tag, " R3 cnt lo"}, int'(mem[loc(pg, 2)]), len & 255);
        chk(mem[loc(pg, 3)] === 8'(len >> 8), {tag, " R3 cnt hi"}, int'(mem[loc(pg, 3)]), len >> 8);
        chk(curr_pg == 8'(nxt), {tag, " R4 curr"}, int'(curr_pg), nxt);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(curr_pg == 8'(FIRST), "R1 curr after reset", int'(curr_pg), FIRST);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_n == 0 && done_n == 0 && ovw_n == 0 && miss_n == 0, "R1 quiet",
            wr_n + done_n + ovw_n + miss_n, 0);
    endtask

    task automatic t_good(input int len, input int seed, input int nxt, input string tag);
        int pg, d0;
        pg = int'(curr_pg);
        d0 = done_n;
        send(len, seed, 8'h01);
        check_frame(tag, pg, len, seed, 8'h01, nxt);
        chk(done_n == d0 + 1, {tag, " R4 done"}, done_n - d0, 1);
    endtask

    task automatic t_overwrite();
        int o0, m0, d0;
        bnd_pg = 8'h12;
        sentinel(8'h12);
        mem[loc(8'h11, 0)] = 8'hEE;
        o0 = ovw_n; m0 = miss_n; d0 = done_n;
        send(300, 8'h40, 8'h01);
        chk(ovw_n == o0 + 1, "R5 warn", ovw_n - o0, 1);
        chk(mem[loc(8'h12, 0)] === 8'hEE && mem[loc(8'h12, 47)] === 8'hEE,
            "R5 boundary page untouched", int'(mem[loc(8'h12, 0)]), 8'hEE);
        chk(miss_n == m0 + 1, "R6 missed", miss_n - m0, 1);
        chk(done_n == d0 && mem[loc(8'h11, 0)] === 8'hEE && curr_pg == 8'h11,
            "R6 not committed", int'(curr_pg), 8'h11);
    endtask

    task automatic t_blocked_start();
        int o0, m0, w0;
        bnd_pg = 8'h11;
        o0 = ovw_n; m0 = miss_n; w0 = wr_n;
        send(1, 8'h00, 8'h01);
        chk(ovw_n == o0 + 1 && miss_n == m0 + 1, "R5 blocked first byte",
            ovw_n - o0 + miss_n - m0, 2);
        chk(wr_n == w0 && curr_pg == 8'h11, "R6 no write on blocked start", wr_n - w0, 0);
    endtask

    task automatic t_errors();
        int d0;
        bnd_pg   = 8'h17;
        keep_bad = 1'b0;
        mem[loc(8'h11, 0)] = 8'hEE;
        d0 = done_n;
        send(70, 8'h80, 8'h03);
        chk(done_n == d0 && curr_pg == 8'h11 && mem[loc(8'h11, 0)] === 8'hEE,
            "R7 crc error dropped", int'(curr_pg), 8'h11);
        send(70, 8'h90, 8'h00);
        chk(done_n == d0 && curr_pg == 8'h11 && mem[loc(8'h11, 0)] === 8'hEE,
            "R7 intact clear dropped", int'(curr_pg), 8'h11);
        keep_bad = 1'b1;
        send(70, 8'hA0, 8'h05);
        check_frame("R8 kept", 8'h11, 70, 8'hA0, 8'h05, 8'h12);
        keep_bad = 1'b0;
    endtask

    task automatic t_exact_fill();
        int o0;
        bnd_pg = 8'h13;
        o0 = ovw_n;
        send(252, 8'h33, 8'h01);
        check_frame("R9 exact fill", 8'h12, 252, 8'h33, 8'h01, 8'h13);
        chk(ovw_n == o0, "R9 no warn", ovw_n - o0, 0);
    endtask

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = 8'hEE;
        t_reset();
        t_good(64, 8'h05, 8'h11, "R2 short");
        t_good(300, 8'h11, 8'h13, "R2 span");
        bnd_pg = 8'h12;
        t_good(1000, 8'h22, 8'h17, "R2 long");
        t_good(300, 8'h61, after(8'h17) + 1, "R2 wrap");
        t_overwrite();
        t_blocked_start();
        t_errors();
        t_exact_fill();
        begin
            int o0, m0;
            o0 = ovw_n; m0 = miss_n;
            send(2, 8'h00, 8'h01);
            chk(ovw_n == o0 + 1 && miss_n == m0 + 1 && curr_pg == 8'h13,
                "R5 full ring after exact fill", ovw_n - o0 + miss_n - m0, 2);
        end
        bnd_pg = 8'h10;
        t_good(253, 8'h7E, 8'h15, "R4 one past fill");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PER * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule